// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block turns a single-cycle write request into one correctly timed write cycle on an external asynchronous static RAM with 128K words of 16 bits. The RAM has active-low chip-enable and write-enable strobes. On the user side, a request/ready handshake carries the address, the write data and a speed-grade select. On the memory side, the block drives the address, the outgoing data word, a data-output-enable for the data pads, and the two strobes.

Every minimum interval of the memory's write timing is a parameter in nanoseconds. At elaboration each interval is turned into a count of system clock cycles, rounded up. A write has three counted phases. In SETUP, chip-enable is low, the bus is driven and write-enable is still high. In PULSE, both strobes are low. In RECOVER, both strobes are high again while the address and data are held. Chip-enable is never asserted after write-enable and never released before it, so every write is ended by the rising edge of write-enable.

The speed grade is sampled together with the request, and it sets the length of all three phases of that write.

Top module: `sram_write_seq`

## Requirements
- R1: While reset is applied and after it is released, ready is 1, both strobes are 1, and data-output-enable is 0.
- R2: A request taken while ready is 1 drops ready on the next cycle. Ready stays 0 for exactly SETUP+PULSE+RECOVER cycles. With the default 5 ns clock this is 17 cycles for the fast grade (slow select 0) and 24 cycles for the slow grade (slow select 1).
- R3: Chip-enable falls on the first busy cycle. Write-enable then stays high for the SETUP length: 2 cycles fast, 3 cycles slow. Write-enable is never low while chip-enable is high.
- R4: Write-enable is low for exactly PULSE cycles: ceil(65/5)=13 fast, ceil(85/5)=17 slow.
- R5: Chip-enable and write-enable rise on the same clock edge, and both stay high through RECOVER: 2 cycles fast, 4 cycles slow.
- R6: The memory address and data outputs carry the values captured with the request from the first busy cycle to the last one. Changes on the user inputs while busy have no effect on them.
- R7: Data-output-enable is 1 from the first busy cycle (at least one cycle before write-enable falls) through the last RECOVER cycle, and 0 when idle.
- R8: A request raised while busy is held off and is not dropped. It is accepted on the first ready cycle and starts a new write on the next cycle.
- R9: The grade select is sampled only when a request is accepted. Changing it during a write does not change that write's phase lengths.
- R10: The phase lengths follow SETUP = max(1, ceil(max(tCE,tAV,tDV)/T) - PULSE) and RECOVER = max(ceil(tREC/T), ceil(tCYC/T) - SETUP - PULSE), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Write request, taken when ready_o is 1 |
| ready_o | output | 1 | Idle and able to accept a request |
| slow_i | input | 1 | Speed grade: 0 fast, 1 slow |
| addr_i | input | 17 | Word address of the write |
| wdata_i | input | 16 | Data word to write |
| mem_addr_o | output | 17 | Address to the memory |
| mem_dq_o | output | 16 | Data to the memory pads |
| mem_dq_oe_o | output | 1 | Drive enable for the data pads |
| mem_ce_n_o | output | 1 | Chip-enable strobe, active low |
| mem_we_n_o | output | 1 | Write-enable strobe, active low |

## Verification
Writes are swept over both grades, with walking-one addresses and data words, and with all-zero and all-one words. A mismatch shows up as a single stuck or swapped bit on the bus, or as a phase length that belongs to the wrong grade. During each isolated write, the inputs are inverted and the grade select is flipped, which separates captured values from values that still follow the inputs. Chained writes with the request held high during the busy period show whether a pending request is kept and restarts exactly one cycle after ready returns.

// File: rtl/sram_wseq_pkg.sv
package sram_wseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_PULSE   = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  function automatic int unsigned cdiv(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // strobe-low width in cycles
  function automatic int unsigned pulse_cycles(input int unsigned wp, input int unsigned clk_ns);
    return umax(1, cdiv(wp, clk_ns));
  endfunction

  // cycles of CE low before WE falls, so CE/address/data lead the end far enough
  function automatic int unsigned setup_cycles(input int unsigned ce_ns, input int unsigned av_ns,
                                               input int unsigned dv_ns, input int unsigned wp,
                                               input int unsigned clk_ns);
    int unsigned lead;
    int unsigned p;
    lead = umax(cdiv(ce_ns, clk_ns), umax(cdiv(av_ns, clk_ns), cdiv(dv_ns, clk_ns)));
    p    = pulse_cycles(wp, clk_ns);
    return (lead > p + 1) ? lead - p : 1;
  endfunction

  // cycles after WE rises; also pads the whole cycle up to its minimum
  function automatic int unsigned recover_cycles(input int unsigned cyc_ns, input int unsigned rec_ns,
                                                 input int unsigned ce_ns, input int unsigned av_ns,
                                                 input int unsigned dv_ns, input int unsigned wp,
                                                 input int unsigned clk_ns);
    int unsigned act;
    int unsigned need;
    int unsigned r;
    act  = setup_cycles(ce_ns, av_ns, dv_ns, wp, clk_ns) + pulse_cycles(wp, clk_ns);
    need = cdiv(cyc_ns, clk_ns);
    r    = umax(1, cdiv(rec_ns, clk_ns));
    return (need > act + r) ? need - act : r;
  endfunction

endpackage

// File: rtl/sram_wseq_timing.sv
module sram_wseq_timing #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned F_SETUP = 2,
  parameter int unsigned F_PULSE = 13,
  parameter int unsigned F_REC   = 2,
  parameter int unsigned S_SETUP = 3,
  parameter int unsigned S_PULSE = 17,
  parameter int unsigned S_REC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic             slow_i,
  output logic [CNT_W-1:0] setup_len_o,
  output logic [CNT_W-1:0] pulse_len_o,
  output logic [CNT_W-1:0] rec_len_o
);

  localparam logic [CNT_W-1:0] LEN_TAB [2][3] = '{
    '{CNT_W'(F_SETUP), CNT_W'(F_PULSE), CNT_W'(F_REC)},
    '{CNT_W'(S_SETUP), CNT_W'(S_PULSE), CNT_W'(S_REC)}
  };

  logic grade_q;
  logic grade_d;
  logic sel;

  // grade register with explicit clock enable
  always_comb begin
    grade_d = grade_q;
    if (capture_i) grade_d = slow_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grade_q <= 1'b0;
    else        grade_q <= grade_d;
  end

  // bypass so the accepting cycle already sees the new grade
  assign sel = capture_i ? slow_i : grade_q;

  always_comb begin
    setup_len_o = LEN_TAB[sel][0];
    pulse_len_o = LEN_TAB[sel][1];
    rec_len_o   = LEN_TAB[sel][2];
  end

endmodule

// File: rtl/sram_wseq_fsm.sv
module sram_wseq_fsm
  import sram_wseq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] setup_len_i,
  input  logic [CNT_W-1:0] pulse_len_i,
  input  logic [CNT_W-1:0] rec_len_i,
  output phase_e           phase_nxt_o,
  output logic             accept_o,
  output logic             ready_o
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last     = (cnt_q == '0);
  assign ready_o  = (ph_q == PH_IDLE);
  assign accept_o = ready_o && req_i;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_i) begin
          ph_d  = PH_SETUP;
          cnt_d = setup_len_i - 1'b1;
        end
      end
      PH_SETUP: begin
        if (last) begin
          ph_d  = PH_PULSE;
          cnt_d = pulse_len_i - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PULSE: begin
        if (last) begin
          ph_d  = PH_RECOVER;
          cnt_d = rec_len_i - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RECOVER: begin
        if (last) ph_d  = PH_IDLE;
        else      cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_nxt_o = ph_d;

  // a taken request must make the block busy on the next cycle
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && req_i) |=> !ready_o);

  // a request pending during the recovery end is taken on the ready cycle
  assert_pending_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && req_i) |=> (ph_q == PH_SETUP));

endmodule

// File: rtl/sram_wseq_path.sv
module sram_wseq_path
  import sram_wseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  phase_e            phase_nxt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic              mem_ce_n_o,
  output logic              mem_we_n_o
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              ce_n_d, we_n_d, oe_d;

  // bus capture with explicit enable
  always_comb begin
    addr_d = mem_addr_o;
    data_d = mem_dq_o;
    if (accept_i) begin
      addr_d = addr_i;
      data_d = wdata_i;
    end
  end

  // strobes decoded from the next phase so every pin comes straight off a flop
  always_comb begin
    ce_n_d = !((phase_nxt_i == PH_SETUP) || (phase_nxt_i == PH_PULSE));
    we_n_d = !(phase_nxt_i == PH_PULSE);
    oe_d   = (phase_nxt_i != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr_o  <= '0;
      mem_dq_o    <= '0;
      mem_dq_oe_o <= 1'b0;
      mem_ce_n_o  <= 1'b1;
      mem_we_n_o  <= 1'b1;
    end else begin
      mem_addr_o  <= addr_d;
      mem_dq_o    <= data_d;
      mem_dq_oe_o <= oe_d;
      mem_ce_n_o  <= ce_n_d;
      mem_we_n_o  <= we_n_d;
    end
  end

  assert_we_within_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> !mem_ce_n_o);

  assert_end_by_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n_o) |-> $rose(mem_we_n_o));

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  assert_drive_before_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n_o) |-> (mem_dq_oe_o && $past(mem_dq_oe_o)));

  assert_strobes_need_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n_o |-> mem_dq_oe_o);

endmodule

// File: rtl/sram_write_seq.sv
module sram_write_seq
  import sram_wseq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CLK_NS  = 5,
  parameter int unsigned F_CYC   = 85,
  parameter int unsigned F_CE    = 75,
  parameter int unsigned F_AV    = 75,
  parameter int unsigned F_WP    = 65,
  parameter int unsigned F_DV    = 35,
  parameter int unsigned F_REC   = 5,
  parameter int unsigned S_CYC   = 120,
  parameter int unsigned S_CE    = 100,
  parameter int unsigned S_AV    = 100,
  parameter int unsigned S_WP    = 85,
  parameter int unsigned S_DV    = 45,
  parameter int unsigned S_REC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              slow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic              mem_ce_n_o,
  output logic              mem_we_n_o
);

  // R10: phase lengths in whole cycles
  localparam int unsigned FS = setup_cycles(F_CE, F_AV, F_DV, F_WP, CLK_NS);
  localparam int unsigned FP = pulse_cycles(F_WP, CLK_NS);
  localparam int unsigned FR = recover_cycles(F_CYC, F_REC, F_CE, F_AV, F_DV, F_WP, CLK_NS);
  localparam int unsigned SS = setup_cycles(S_CE, S_AV, S_DV, S_WP, CLK_NS);
  localparam int unsigned SP = pulse_cycles(S_WP, CLK_NS);
  localparam int unsigned SR = recover_cycles(S_CYC, S_REC, S_CE, S_AV, S_DV, S_WP, CLK_NS);
  localparam int unsigned MAX_LEN = umax(umax(umax(FS, FP), umax(FR, SS)), umax(SP, SR));
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             accept;
  phase_e           phase_nxt;
  logic [CNT_W-1:0] setup_len, pulse_len, rec_len;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sram_wseq_timing #(
    .CNT_W(CNT_W),
    .F_SETUP(FS), .F_PULSE(FP), .F_REC(FR),
    .S_SETUP(SS), .S_PULSE(SP), .S_REC(SR)
  ) u_timing (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .capture_i  (accept),
    .slow_i     (slow_i),
    .setup_len_o(setup_len),
    .pulse_len_o(pulse_len),
    .rec_len_o  (rec_len)
  );

  sram_wseq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_i      (req_i),
    .setup_len_i(setup_len),
    .pulse_len_i(pulse_len),
    .rec_len_i  (rec_len),
    .phase_nxt_o(phase_nxt),
    .accept_o   (accept),
    .ready_o    (ready_o)
  );

  sram_wseq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept_i   (accept),
    .phase_nxt_i(phase_nxt),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_we_n_o (mem_we_n_o)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    ready_o |-> (mem_ce_n_o && mem_we_n_o && !mem_dq_oe_o));

endmodule

// File: tb/sram_write_seq_test.sv
`timescale 1ns/1ps
module sram_write_seq_test;

  logic        clk;
  logic        rst_n;
  logic        req_i, slow_i;
  logic [16:0] addr_i;
  logic [15:0] wdata_i;
  logic        ready_o, mem_dq_oe_o, mem_ce_n_o, mem_we_n_o;
  logic [16:0] mem_addr_o;
  logic [15:0] mem_dq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sram_write_seq uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ready_o(ready_o), .slow_i(slow_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o), .mem_ce_n_o(mem_ce_n_o), .mem_we_n_o(mem_we_n_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // R10 arithmetic with a 5 ns clock
  task automatic lengths(input bit s, output int S, output int P, output int R);
    int cyc, ce, wp, lead, rec;
    cyc = s ? 120 : 85;
    ce  = s ? 100 : 75;
    wp  = s ? 85  : 65;
    rec = 5;
    P    = cdiv(wp, 5);
    lead = cdiv(ce, 5);
    S    = (lead > P + 1) ? lead - P : 1;
    R    = (cdiv(cyc, 5) > S + P + cdiv(rec, 5)) ? cdiv(cyc, 5) - S - P : cdiv(rec, 5);
  endtask

  // one write; called at a negedge with ready expected high
  task automatic txn(input logic [16:0] a, input logic [15:0] d, input bit s,
                     input bit chain, input logic [16:0] na, input logic [15:0] nd, input bit ns);
    int S, P, R, T;
    int bad_setup, bad_end, bad_we, bad_oe, bad_bus, busy, we_low;
    lengths(s, S, P, R);
    T = S + P + R;
    bad_setup = 0; bad_end = 0; bad_we = 0; bad_oe = 0; bad_bus = 0; busy = 0; we_low = 0;
    chk(ready_o == 1'b1, "R8 ready before accept", ready_o, 1);
    req_i = 1'b1; addr_i = a; wdata_i = d; slow_i = s;
    @(posedge clk); @(negedge clk);
    for (int i = 0; i <= T; i++) begin
      if (i == 1) begin
        if (chain) begin
          addr_i = na; wdata_i = nd; slow_i = ns; req_i = 1'b1;
        end else begin
          req_i = 1'b0; addr_i = ~a; wdata_i = ~d; slow_i = ~s;
        end
      end
      if (!ready_o) busy++;
      if (!mem_we_n_o) we_low++;
      if (i < S + P) begin
        if (mem_ce_n_o !== 1'b0) bad_setup++;
      end else begin
        if (mem_ce_n_o !== 1'b1) bad_end++;
      end
      if (mem_we_n_o !== ((i >= S && i < S + P) ? 1'b0 : 1'b1)) bad_we++;
      if (mem_dq_oe_o !== (i < T)) bad_oe++;
      if (i < T && (mem_addr_o !== a || mem_dq_o !== d)) bad_bus++;
      if (i < T) @(negedge clk);
    end
    chk(busy == T, "R2 busy length", busy, T);
    chk(busy == T, "R9 grade sampled at accept", busy, T);
    chk(bad_setup == 0, "R3 CE low through setup and pulse", bad_setup, 0);
    chk(bad_we == 0, "R3 WE waveform", bad_we, 0);
    chk(we_low == P, "R4 WE pulse width", we_low, P);
    chk(bad_end == 0, "R5 CE released with WE", bad_end, 0);
    chk(bad_bus == 0, "R6 bus held", bad_bus, 0);
    chk(bad_oe == 0, "R7 output enable window", bad_oe, 0);
    chk(ready_o == 1'b1, "R2 ready after recovery", ready_o, 1);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int S, P, R;
    rst_n = 1'b0; req_i = 1'b0; slow_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready_o && mem_ce_n_o && mem_we_n_o && !mem_dq_oe_o, "R1 outputs in reset",
        {ready_o, mem_ce_n_o, mem_we_n_o, mem_dq_oe_o}, 4'b1110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready_o && mem_ce_n_o && mem_we_n_o && !mem_dq_oe_o, "R1 outputs after release",
        {ready_o, mem_ce_n_o, mem_we_n_o, mem_dq_oe_o}, 4'b1110);

    // R10 expected lengths, default clock
    lengths(1'b0, S, P, R);
    chk(S == 2 && P == 13 && R == 2, "R10 fast lengths", S * 10000 + P * 100 + R, 21302);
    lengths(1'b1, S, P, R);
    chk(S == 3 && P == 17 && R == 4, "R10 slow lengths", S * 10000 + P * 100 + R, 31704);

    // walking ones, both grades
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 17; k++) begin
        txn(17'(1) << k, 16'(1) << (k % 16) ^ 16'(g * 16'h5a5a), g[0], 1'b0, '0, '0, 1'b0);
        @(negedge clk);
      end
    end
    txn('0, '0, 1'b0, 1'b0, '0, '0, 1'b0);
    txn('1, '1, 1'b1, 1'b0, '0, '0, 1'b0);

    // chained writes, request held through busy (R8)
    txn(17'h0abcd, 16'h1234, 1'b0, 1'b1, 17'h15432, 16'hbeef, 1'b1);
    txn(17'h15432, 16'hbeef, 1'b1, 1'b1, 17'h00001, 16'h8001, 1'b0);
    txn(17'h00001, 16'h8001, 1'b0, 1'b1, 17'h1ffff, 16'h0000, 1'b1);
    txn(17'h1ffff, 16'h0000, 1'b1, 1'b0, '0, '0, 1'b0);
    repeat (3) @(negedge clk);
    chk(ready_o && mem_ce_n_o && !mem_dq_oe_o, "R8 no extra write after chain",
        {ready_o, mem_ce_n_o, mem_dq_oe_o}, 3'b110);

    done = 1;
    summary();
    $finish;
  end

endmodule